// File: doc/BRIEF.md
# Buffered Timer Compare Channel

This block is a single compare channel attached to an 8-bit timer. It receives the running counter value, a tick enable, the count direction, TOP and BOTTOM indicators and the current mode class (PWM or not, and single- or dual-slope). From these it decides when the counter equals the programmed compare value. It then drives a one-cycle match pulse, a sticky match flag and an output register whose next state depends on the two compare-output mode bits.

In PWM modes, a compare value written by the CPU is held in a buffer. It is moved to the active comparator at a fixed point of the count: BOTTOM for single-slope and TOP for dual-slope. Outside PWM, the write reaches the comparator at once. A write to the counter blanks the comparator for the next tick. A force strobe can drive the output in non-PWM modes without touching the flag. A small multiplexer hands the pin either the output register or the ordinary port value, and passes the direction bit on as the pin enable.

All pins carry control and status, not a data stream, so no valid/ready handshake exists. Every input is sampled on each rising edge of `clk`.

Top module: `ocu_channel`

## Requirements
- R1: When `pwm_mode`=1, `cmp_wr` loads only the buffer. The active value `cmp_now` takes the buffer contents at an edge where `tick`=1 and the load point is present (`at_bottom` when `pwm_dual`=0, `at_top` when `pwm_dual`=1), and is otherwise unchanged.
- R2: When `pwm_mode`=0, `cmp_wr` sets `cmp_now` to `cmp_wdata` at that edge.
- R3: At an edge where `tick`=1 and `cnt`==`cmp_now` and matching is not blanked, `match_pulse` is high for the following cycle and `match_flag` becomes 1.
- R4: `match_flag` clears when `flag_clr` or `irq_ack` is 1 at an edge. A match at the same edge wins and leaves the flag set.
- R5: After an edge with `cnt_wr`=1, the next edge with `tick`=1 produces no match, whether or not the timer was ticking in between.
- R6: With `pwm_mode`=0, `force_stb` applies the compare-output action to `oc_q` but leaves `match_flag` unchanged. With `pwm_mode`=1, `force_stb` has no effect.
- R7: With `pwm_mode`=0, a match applies an action set by `com`: 0 leaves `oc_q` unchanged, 1 toggles it, 2 clears it, 3 sets it. A change of `com` applies at the very next edge.
- R8: With `pwm_mode`=1 and `pwm_dual`=0, `com`=2 clears `oc_q` on a match and sets it on a tick with `at_top`=1. `com`=3 does the opposite. The TOP action wins when both fall on one tick.
- R9: With `pwm_mode`=1 and `pwm_dual`=1, `com`=2 clears `oc_q` on a match while `cnt_down`=0 and sets it on a match while `cnt_down`=1. `com`=3 does the opposite.
- R10: `oc_q` is 0 after reset and keeps its value when the mode inputs change.
- R11: `pin_val` is `oc_q` when `com` is nonzero and `port_val` when it is 0. `pin_oe` follows `dir_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer tick enable for this cycle |
| cnt | input | W | Current counter value |
| cnt_down | input | 1 | 1 while the counter is decrementing |
| at_top | input | 1 | Counter is at TOP |
| at_bottom | input | 1 | Counter is at BOTTOM |
| pwm_mode | input | 1 | Current mode is a PWM mode |
| pwm_dual | input | 1 | PWM mode is dual-slope |
| cmp_wr | input | 1 | CPU write of the compare value |
| cmp_wdata | input | W | Compare value written |
| cnt_wr | input | 1 | CPU wrote the counter |
| flag_clr | input | 1 | Software write of one to the match flag |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| force_stb | input | 1 | Force-compare strobe |
| com | input | 2 | Compare-output mode bits |
| dir_out | input | 1 | Pin direction: 1 = output |
| port_val | input | 1 | Ordinary port data for the pin |
| cmp_now | output | W | Active compare value |
| match_pulse | output | 1 | One-cycle match indication |
| match_flag | output | 1 | Sticky match flag |
| oc_q | output | 1 | Output compare register |
| pin_val | output | 1 | Value offered to the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
The registered results (`cmp_now`, `match_pulse`, `match_flag`, `oc_q`) are due one cycle after the stimulus edge, so they are read just after that edge. The blanking rule in R5 spans two ticks: the first tick after a counter write must show nothing, and the second must show a match. The combinational pin outputs (`pin_val`, `pin_oe`) are due in the same cycle as their inputs, and are read only after those inputs have settled. Every check is queued by the driver at the moment its result is due, and the monitor compares the queue immediately, before the driver moves any input.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  typedef enum logic [1:0] {
    COM_NONE   = 2'd0,
    COM_TOGGLE = 2'd1,
    COM_CLEAR  = 2'd2,
    COM_SET    = 2'd3
  } com_e;
endpackage

// File: rtl/ocu_cmp_reg.sv
module ocu_cmp_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwm_mode,
  input  logic         load_now,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  output logic [W-1:0] cmp_act
);
  logic [W-1:0] buf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q   <= '0;
      cmp_act <= '0;
    end else begin
      if (cmp_wr) buf_q <= cmp_wdata;
      if (!pwm_mode && cmp_wr)      cmp_act <= cmp_wdata;
      else if (pwm_mode && load_now) cmp_act <= buf_q;
    end
  end

  // R1: outside the load point the active value holds in PWM modes
  a_r1_hold_between_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && !load_now) |=> $stable(cmp_act));
  // R2: direct write outside PWM
  a_r2_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_mode && cmp_wr) |=> (cmp_act == $past(cmp_wdata)));
endmodule

// File: rtl/ocu_match.sv
module ocu_match #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp_act,
  input  logic         cnt_wr,
  input  logic         flag_clr,
  input  logic         irq_ack,
  output logic         match_evt,
  output logic         match_pulse,
  output logic         match_flag
);
  logic blank_q;

  assign match_evt = tick && !blank_q && (cnt == cmp_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blank_q     <= 1'b0;
      match_pulse <= 1'b0;
      match_flag  <= 1'b0;
    end else begin
      if (cnt_wr)    blank_q <= 1'b1;
      else if (tick) blank_q <= 1'b0;
      match_pulse <= match_evt;
      if (match_evt)                 match_flag <= 1'b1;
      else if (flag_clr || irq_ack)  match_flag <= 1'b0;
    end
  end

  // R3: an accepted match raises pulse and flag on the next cycle
  a_r3_match_marks: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> (match_pulse && match_flag));
  // R4: a clear without a match empties the flag
  a_r4_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_clr || irq_ack) && !match_evt) |=> !match_flag);
  // R5: a counter write blanks the following cycle's comparison
  a_r5_write_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> !match_evt);
endmodule

// File: rtl/ocu_wavegen.sv
module ocu_wavegen
  import ocu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_mode,
  input  logic pwm_dual,
  input  logic tick,
  input  logic at_top,
  input  logic cnt_down,
  input  logic match_evt,
  input  logic force_stb,
  input  com_e com,
  output logic oc_q
);
  logic oc_nxt;
  logic hit_lvl;

  // level driven on a match in PWM modes: com bit 0 selects inverted sense
  assign hit_lvl = com[0];

  always_comb begin
    oc_nxt = oc_q;
    if (!pwm_mode) begin
      if (match_evt || force_stb) begin
        unique case (com)
          COM_TOGGLE: oc_nxt = ~oc_q;
          COM_CLEAR:  oc_nxt = 1'b0;
          COM_SET:    oc_nxt = 1'b1;
          default:    oc_nxt = oc_q;
        endcase
      end
    end else if (!pwm_dual) begin
      if (com[1]) begin
        if (tick && at_top)  oc_nxt = ~hit_lvl;
        else if (match_evt)  oc_nxt = hit_lvl;
      end
    end else begin
      if (com[1] && match_evt) oc_nxt = cnt_down ? ~hit_lvl : hit_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) oc_q <= 1'b0;
    else        oc_q <= oc_nxt;
  end

  // R7: mode 0 never changes the output register
  a_r7_none_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (com == COM_NONE) |=> $stable(oc_q));
  // R6: a force strobe alone does nothing in PWM modes
  a_r6_force_ignored_pwm: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && force_stb && !match_evt && !(tick && at_top)) |=> $stable(oc_q));
endmodule

// File: rtl/ocu_channel.sv
module ocu_channel
  import ocu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic         cnt_down,
  input  logic         at_top,
  input  logic         at_bottom,
  input  logic         pwm_mode,
  input  logic         pwm_dual,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic         cnt_wr,
  input  logic         flag_clr,
  input  logic         irq_ack,
  input  logic         force_stb,
  input  logic [1:0]   com,
  input  logic         dir_out,
  input  logic         port_val,
  output logic [W-1:0] cmp_now,
  output logic         match_pulse,
  output logic         match_flag,
  output logic         oc_q,
  output logic         pin_val,
  output logic         pin_oe
);
  logic load_now;
  logic match_evt;
  com_e com_sel;

  assign com_sel  = com_e'(com);
  assign load_now = tick && (pwm_dual ? at_top : at_bottom);

  ocu_cmp_reg #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .pwm_mode(pwm_mode), .load_now(load_now),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .cmp_act(cmp_now)
  );

  ocu_match #(.W(W)) u_match (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .cmp_act(cmp_now),
    .cnt_wr(cnt_wr), .flag_clr(flag_clr), .irq_ack(irq_ack),
    .match_evt(match_evt), .match_pulse(match_pulse), .match_flag(match_flag)
  );

  ocu_wavegen u_wave (
    .clk(clk), .rst_n(rst_n), .pwm_mode(pwm_mode), .pwm_dual(pwm_dual),
    .tick(tick), .at_top(at_top), .cnt_down(cnt_down), .match_evt(match_evt),
    .force_stb(force_stb), .com(com_sel), .oc_q(oc_q)
  );

  assign pin_val = (com != 2'd0) ? oc_q : port_val;
  assign pin_oe  = dir_out;

  // R6: a force strobe never raises the flag
  a_r6_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (force_stb && !match_evt && !match_flag) |=> !match_flag);
  // R10: the output register is zero right after reset
  a_r10_reset_zero: assert property (@(posedge clk)
    !rst_n |=> !oc_q);
endmodule

// File: tb/ocu_channel_tb_top.sv
`timescale 1ns/1ps
module ocu_channel_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, cnt_down = 0, at_top = 0, at_bottom = 0;
  logic pwm_mode = 0, pwm_dual = 0, cmp_wr = 0, cnt_wr = 0;
  logic flag_clr = 0, irq_ack = 0, force_stb = 0, dir_out = 0, port_val = 1;
  logic [W-1:0] cnt = '0, cmp_wdata = '0;
  logic [1:0] com = 2'd0;
  logic [W-1:0] cmp_now;
  logic match_pulse, match_flag, oc_q, pin_val, pin_oe;

  always #2.5 clk = ~clk;

  ocu_channel #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .cnt_down(cnt_down),
    .at_top(at_top), .at_bottom(at_bottom), .pwm_mode(pwm_mode),
    .pwm_dual(pwm_dual), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .cnt_wr(cnt_wr), .flag_clr(flag_clr), .irq_ack(irq_ack),
    .force_stb(force_stb), .com(com), .dir_out(dir_out), .port_val(port_val),
    .cmp_now(cmp_now), .match_pulse(match_pulse), .match_flag(match_flag),
    .oc_q(oc_q), .pin_val(pin_val), .pin_oe(pin_oe)
  );

  typedef struct {
    string tag;
    int    sel;
    int    val;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  event mon_ev;

  localparam int S_CMP = 0, S_PULSE = 1, S_FLAG = 2, S_OC = 3, S_PIN = 4, S_OE = 5;

  function automatic int observe(int sel);
    case (sel)
      S_CMP:   return int'(cmp_now);
      S_PULSE: return int'(match_pulse);
      S_FLAG:  return int'(match_flag);
      S_OC:    return int'(oc_q);
      S_PIN:   return int'(pin_val);
      default: return int'(pin_oe);
    endcase
  endfunction

  // monitor: pops the expected items and compares against the outputs
  initial begin
    forever begin
      @(mon_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        int got;
        e = exp_q.pop_front();
        got = observe(e.sel);
        n_cmp++;
        if (got !== e.val) begin
          n_bad++;
          $display("FAIL %s: output %0d got 0x%0h expected 0x%0h", e.tag, e.sel, got, e.val);
        end
      end
    end
  end

  task automatic push(string tag, int sel, int val);
    exp_t e;
    e.tag = tag; e.sel = sel; e.val = val;
    exp_q.push_back(e);
  endtask

  task automatic flush();
    -> mon_ev;
    #1;
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic clr_flag();
    flag_clr = 1; cyc(); flag_clr = 0; flush();
  endtask

  task automatic tick_at(logic [W-1:0] v);
    cnt = v; tick = 1; cyc(); tick = 0; flush();
  endtask

  bit done = 0;

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1; cyc();
    push("R10", S_OC, 0); push("R3", S_FLAG, 0); push("R3", S_PULSE, 0);
    push("R2", S_CMP, 0); push("R11", S_PIN, 1); push("R11", S_OE, 0);
    flush();

    // R2 direct write
    cmp_wdata = 8'h10; cmp_wr = 1; cyc(); cmp_wr = 0;
    push("R2", S_CMP, 8'h10); flush();

    // R3 match pulse and flag, R7 mode 0 holds
    tick_at(8'h10);
    push("R3", S_PULSE, 1); push("R3", S_FLAG, 1); push("R7", S_OC, 0); flush();
    cyc(); push("R3", S_PULSE, 0); push("R3", S_FLAG, 1); flush();

    // R4 clears
    clr_flag(); push("R4", S_FLAG, 0); flush();
    tick_at(8'h10);
    irq_ack = 1; cyc(); irq_ack = 0; push("R4", S_FLAG, 0); flush();
    cnt = 8'h10; tick = 1; flag_clr = 1; cyc(); tick = 0; flag_clr = 0;
    push("R4", S_FLAG, 1); flush();
    clr_flag();

    // R5 counter write blanking
    cnt_wr = 1; cyc(); cnt_wr = 0; flush();
    tick_at(8'h10); push("R5", S_FLAG, 0); push("R5", S_PULSE, 0); flush();
    tick_at(8'h10); push("R5", S_FLAG, 1); flush();
    clr_flag();

    // R7 non-PWM actions
    com = 2'd1; tick_at(8'h10); push("R7", S_OC, 1); flush();
    tick_at(8'h10); push("R7", S_OC, 0); flush();
    com = 2'd3; tick_at(8'h10); push("R7", S_OC, 1); flush();
    com = 2'd2; tick_at(8'h10); push("R7", S_OC, 0); flush();
    dir_out = 1; cyc(); push("R11", S_PIN, 0); push("R11", S_OE, 1); flush();
    clr_flag();

    // R6 force without flag
    com = 2'd3; cnt = 8'h22; force_stb = 1; cyc(); force_stb = 0;
    push("R6", S_OC, 1); push("R6", S_FLAG, 0); flush();
    pwm_mode = 1; com = 2'd2; force_stb = 1; cyc(); force_stb = 0;
    push("R6", S_OC, 1); flush();

    // R1 fast PWM buffering at BOTTOM
    cmp_wdata = 8'h40; cmp_wr = 1; cyc(); cmp_wr = 0;
    push("R1", S_CMP, 8'h10); flush();
    tick_at(8'h22); push("R1", S_CMP, 8'h10); flush();
    at_bottom = 1; tick_at(8'h00); at_bottom = 0;
    push("R1", S_CMP, 8'h40); flush();

    // R8 fast PWM output
    tick_at(8'h40); push("R8", S_OC, 0); flush();
    at_top = 1; tick_at(8'hFF); at_top = 0; push("R8", S_OC, 1); flush();
    com = 2'd3;
    at_top = 1; tick_at(8'hFF); at_top = 0; push("R8", S_OC, 0); flush();
    tick_at(8'h40); push("R8", S_OC, 1); flush();

    // R1 dual-slope buffering at TOP
    pwm_dual = 1;
    cmp_wdata = 8'h50; cmp_wr = 1; cyc(); cmp_wr = 0; flush();
    at_bottom = 1; tick_at(8'h00); at_bottom = 0;
    push("R1", S_CMP, 8'h40); flush();
    at_top = 1; tick_at(8'hFF); at_top = 0;
    push("R1", S_CMP, 8'h50); flush();

    // R9 dual-slope output
    com = 2'd2; cnt_down = 0; tick_at(8'h50); push("R9", S_OC, 0); flush();
    cnt_down = 1; tick_at(8'h50); push("R9", S_OC, 1); flush();
    com = 2'd3; tick_at(8'h50); push("R9", S_OC, 0); flush();
    cnt_down = 0; tick_at(8'h50); push("R9", S_OC, 1); flush();

    // R10 value kept across mode change
    pwm_mode = 0; pwm_dual = 0; com = 2'd2; cnt = 8'h22; force_stb = 1; cyc();
    force_stb = 0; push("R7", S_OC, 0); flush();
    pwm_mode = 1; com = 2'd0; cyc(); push("R10", S_OC, 0); flush();
    pwm_mode = 0; com = 2'd3; force_stb = 1; cyc(); force_stb = 0; flush();
    pwm_mode = 1; pwm_dual = 1; com = 2'd0; cyc(); push("R10", S_OC, 1); flush();

    // R11 pin multiplexing
    port_val = 0; cyc(); push("R11", S_PIN, 0); flush();
    com = 2'd2; cyc(); push("R11", S_PIN, 1); flush();
    dir_out = 0; cyc(); push("R11", S_OE, 0); flush();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule